// File: doc/BRIEF.md
# Timer with Shared Assignable Prescaler

The block is an 8-bit up-counter for timing and event counting. Each count event comes from one of two sources: the instruction-cycle enable pulse generated elsewhere in the chip, or an external pin. The external pin is first resynchronized, and then one of its edges is picked by a control bit. A single 8-bit prescaler sits between the source and the counter. The same prescaler can instead be handed to the watchdog path, where it divides the incoming watchdog tick. When the prescaler belongs to the watchdog, the counter sees every source event undivided. When it belongs to the counter, the watchdog tick passes straight through.

Software reaches three registers through a synchronous port: the counter, the control register and an overflow flag. A write to the flag address clears the flag. The counter wraps from 0xFF to 0x00 and sets the flag. Writing the counter, or changing which path owns the prescaler, empties the prescaler so that the next division starts from a clean boundary.

Top module: `tmr_presc_top`

## Requirements
- R1: After reset, the control register (address 1) reads 0xFF, the counter (address 0) reads 0x00, the flag (address 2, bit 0) reads 0 and address 3 reads 0x00.
- R2: With control bit 5 at 0, each cycle with `icyc_en` high is one source event.
- R3: With control bit 5 at 1, the pin passes two synchronizing flops, and a detected edge is one source event. Control bit 4 at 0 selects low-to-high edges and at 1 selects high-to-low edges. A pin change is counted at the third rising clock edge after it is applied.
- R4: With control bit 3 at 0, the counter advances once per 2^(n+1) source events, where n is control bits 2:0.
- R5: With control bit 3 at 1, the counter advances on every source event. `wdt_tick_out` pulses once per 2^n `wdt_tick_in` pulses, so n=0 passes every tick.
- R6: With control bit 3 at 0, `wdt_tick_out` equals `wdt_tick_in` in the same cycle.
- R7: An advance from 0xFF gives 0x00 and sets the flag, which stays set.
- R8: A write to address 2 clears the flag, unless an overflow occurs in the same cycle, in which case the flag stays set.
- R9: A write to address 0 loads the counter, overrides any advance in that cycle and empties the prescaler.
- R10: A control write that changes bit 3 empties the prescaler. A control write that keeps bit 3 unchanged leaves the prescaler's progress intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 counter, 1 control, 2 flag |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| t_ext_pin | input | 1 | External count pin, asynchronous |
| icyc_en | input | 1 | Instruction-cycle enable pulse |
| wdt_tick_in | input | 1 | Undivided watchdog tick |
| ovf_flag | output | 1 | Sticky counter overflow flag |
| wdt_tick_out | output | 1 | Watchdog tick after the optional prescaler |

## Verification
Two events can fall in the same cycle and are checked here. The first is a counter overflow coinciding with a software flag clear. The bench loads 0xFF with no event pending, then in the next cycle raises `icyc_en` and writes address 2 together; the flag must read 1 afterwards. The second is a counter write coinciding with a prescaled advance. The bench judges both against a behavioural model that is compared on every clock, and the model also compares every cycle of a long stretch of mixed random traffic.

// File: rtl/tps_pkg.sv
// Shared constants and types of the timer/prescaler block.
// Assumes an 8-bit datapath, so the rate field is 3 bits wide.
package tps_pkg;
    localparam int DATA_W   = 8;
    localparam int RATE_W   = 3;
    localparam int SYNC_N   = 2;

    // Control register field positions
    localparam int CTL_RATE_LSB = 0;
    localparam int CTL_OWN_BIT  = 3;   // 1: prescaler serves the watchdog
    localparam int CTL_EDGE_BIT = 4;   // 1: count falling pin edges
    localparam int CTL_SRC_BIT  = 5;   // 1: count external pin

    typedef enum logic [1:0] {
        ADDR_CNT  = 2'd0,
        ADDR_CTRL = 2'd1,
        ADDR_FLAG = 2'd2,
        ADDR_NONE = 2'd3
    } tps_addr_e;
endpackage

// File: rtl/tps_ext_sync.sv
// Resynchronizes an asynchronous pin through SYNC_N flops and flags
// rising and falling edges of the synchronized level, one cycle wide.
// Assumes pin pulses last longer than one clock period.
module tps_ext_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [SYNC_N:0] chain_q;

    // Shift the pin through the synchronizer and one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_N-1:0], pin};
    end

    // Compare newest synchronized level against the previous one
    always_comb begin
        rise = chain_q[SYNC_N-1] & ~chain_q[SYNC_N];
        fall = ~chain_q[SYNC_N-1] & chain_q[SYNC_N];
    end
endmodule

// File: rtl/tps_prescaler.sv
// Binary prescaler that emits one tick per 2^k input events.
// k = rate + 1 on the counter path and k = rate on the watchdog path.
// A clear empties it and suppresses any tick in the same cycle.
module tps_prescaler #(
    parameter int W      = 8,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ev_in,
    input  logic              to_wdt,
    input  logic [RATE_W-1:0] rate,
    output logic              tick,
    output logic [W-1:0]      psc_q
);
    logic [RATE_W:0] shamt;
    logic [W:0]      mask_full;
    logic [W-1:0]    mask;

    // Build the low-bit mask whose all-ones state ends a division period
    always_comb begin
        shamt     = {1'b0, rate} + (to_wdt ? {(RATE_W+1){1'b0}} : {{RATE_W{1'b0}}, 1'b1});
        mask_full = ({{W{1'b0}}, 1'b1} << shamt) - {{W{1'b0}}, 1'b1};
        mask      = mask_full[W-1:0];
        tick      = ev_in & ~clr & ((psc_q & mask) == mask);
    end

    // Count input events, or empty on clear
    always_ff @(posedge clk) begin
        if (!rst_n)     psc_q <= '0;
        else if (clr)   psc_q <= '0;
        else if (ev_in) psc_q <= psc_q + {{(W-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/tps_counter.sv
// Loadable up-counter with a sticky overflow flag.
// A load beats an advance; an overflow beats a flag clear.
module tps_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         flag_clr,
    output logic [W-1:0] cnt_q,
    output logic         ovf_q
);
    logic wrap;

    // An advance at all-ones that is not overridden by a load
    always_comb wrap = adv & ~load & (&cnt_q);

    // Counter register: load, advance or hold
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (adv)  cnt_q <= cnt_q + {{(W-1){1'b0}}, 1'b1};
    end

    // Sticky flag: set on wrap, cleared by software otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_q <= 1'b0;
        else if (wrap)     ovf_q <= 1'b1;
        else if (flag_clr) ovf_q <= 1'b0;
    end
endmodule

// File: rtl/tmr_presc_top.sv
// Timer with a prescaler shared between the counter and the watchdog.
// Holds the control register, picks the event source, steers the
// prescaler and decodes the register port. Reads are combinational.
module tmr_presc_top
    import tps_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_we,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         t_ext_pin,
    input  logic         icyc_en,
    input  logic         wdt_tick_in,
    output logic         ovf_flag,
    output logic         wdt_tick_out
);
    logic [W-1:0]      ctrl_q;
    logic [W-1:0]      cnt_q;
    logic [W-1:0]      psc_q;
    logic              pin_rise, pin_fall, pin_ev;
    logic              src_ev, psc_in, psc_tick, psc_clr;
    logic              cnt_tick, cnt_wr, ctrl_wr, flag_wr;
    logic              own_wdt;
    logic [RATE_W-1:0] rate;

    // Register write decode
    always_comb begin
        cnt_wr  = reg_we & (tps_addr_e'(reg_addr) == ADDR_CNT);
        ctrl_wr = reg_we & (tps_addr_e'(reg_addr) == ADDR_CTRL);
        flag_wr = reg_we & (tps_addr_e'(reg_addr) == ADDR_FLAG);
    end

    // Control register, all ones after reset
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '1;
        else if (ctrl_wr) ctrl_q <= reg_wdata;
    end

    tps_ext_sync #(.SYNC_N(SYNC_N)) sync_i (
        .clk(clk), .rst_n(rst_n), .pin(t_ext_pin),
        .rise(pin_rise), .fall(pin_fall)
    );

    // Source selection and prescaler steering
    always_comb begin
        own_wdt  = ctrl_q[CTL_OWN_BIT];
        rate     = ctrl_q[CTL_RATE_LSB +: RATE_W];
        pin_ev   = ctrl_q[CTL_EDGE_BIT] ? pin_fall : pin_rise;
        src_ev   = ctrl_q[CTL_SRC_BIT] ? pin_ev : icyc_en;
        psc_in   = own_wdt ? wdt_tick_in : src_ev;
        psc_clr  = cnt_wr | (ctrl_wr & (reg_wdata[CTL_OWN_BIT] != own_wdt));
    end

    tps_prescaler #(.W(W), .RATE_W(RATE_W)) psc_i (
        .clk(clk), .rst_n(rst_n), .clr(psc_clr), .ev_in(psc_in),
        .to_wdt(own_wdt), .rate(rate), .tick(psc_tick), .psc_q(psc_q)
    );

    // Route the prescaler output to its owner, bypass the other path
    always_comb begin
        cnt_tick     = own_wdt ? src_ev : psc_tick;
        wdt_tick_out = own_wdt ? psc_tick : wdt_tick_in;
    end

    tps_counter #(.W(W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .adv(cnt_tick), .load(cnt_wr),
        .load_val(reg_wdata), .flag_clr(flag_wr),
        .cnt_q(cnt_q), .ovf_q(ovf_flag)
    );

    // Read mux
    always_comb begin
        case (tps_addr_e'(reg_addr))
            ADDR_CNT:  reg_rdata = cnt_q;
            ADDR_CTRL: reg_rdata = ctrl_q;
            ADDR_FLAG: reg_rdata = {{(W-1){1'b0}}, ovf_flag};
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tps_checker.sv
// Property checker for tmr_presc_top, attached through bind.
module tps_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] ctrl_q,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] psc_q,
    input logic         ovf_flag,
    input logic         cnt_tick,
    input logic         src_ev,
    input logic         cnt_wr,
    input logic         flag_wr,
    input logic         psc_clr,
    input logic         wdt_tick_in,
    input logic         wdt_tick_out,
    input logic [W-1:0] reg_wdata
);
    // R5
    wdt_owned_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[3] && src_ev && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R6
    wdt_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[3] |-> (wdt_tick_out == wdt_tick_in));

    // R7
    wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && (&cnt_q) && !cnt_wr) |=> (ovf_flag && cnt_q == '0));

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !(cnt_tick && (&cnt_q) && !cnt_wr)) |=> !ovf_flag);

    // R9
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(reg_wdata) && psc_q == '0));

    // R10
    psc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psc_clr |=> (psc_q == '0));
endmodule

bind tmr_presc_top tps_checker #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .cnt_q(cnt_q), .psc_q(psc_q),
    .ovf_flag(ovf_flag), .cnt_tick(cnt_tick), .src_ev(src_ev),
    .cnt_wr(cnt_wr), .flag_wr(flag_wr), .psc_clr(psc_clr),
    .wdt_tick_in(wdt_tick_in), .wdt_tick_out(wdt_tick_out),
    .reg_wdata(reg_wdata)
);

// File: tb/tmr_presc_top_tb.sv
// Bench for tmr_presc_top: a behavioural model is stepped alongside the
// design and compared on every clock.
module tmr_presc_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       t_ext_pin = 1'b0;
    logic       icyc_en = 1'b0;
    logic       wdt_tick_in = 1'b0;
    logic       ovf_flag;
    logic       wdt_tick_out;

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    bit done = 1'b0;

    // model state
    int  m_ctrl, m_cnt, m_ev;
    bit  m_flag;
    bit  pin_hist[$];

    always #10 clk = ~clk;   // 50 MHz

    tmr_presc_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .t_ext_pin(t_ext_pin),
        .icyc_en(icyc_en), .wdt_tick_in(wdt_tick_in), .ovf_flag(ovf_flag),
        .wdt_tick_out(wdt_tick_out)
    );

    task automatic check(string req, int act, int exp_v, string what);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp_v, $time);
        end
    endtask

    function automatic void model_reset();
        m_ctrl = 8'hFF; m_cnt = 0; m_ev = 0; m_flag = 0;
        pin_hist.delete();
        for (int i = 0; i < 3; i++) pin_hist.push_back(1'b0);
    endfunction

    // One clock: compare outputs with the model, then advance the model.
    task automatic cyc();
        bit own, src_ev, p_in, clr, ptick, ctick, newest, older;
        int div, exp_rd;
        #1;
        own    = m_ctrl[3];
        newest = pin_hist[1];          // second synchronizer stage
        older  = pin_hist[0];          // history stage
        if (m_ctrl[5]) src_ev = m_ctrl[4] ? (older && !newest) : (!older && newest);
        else           src_ev = icyc_en;
        p_in  = own ? wdt_tick_in : src_ev;
        div   = own ? (1 << (m_ctrl & 7)) : (2 << (m_ctrl & 7));
        clr   = reg_we && (reg_addr == 0 || (reg_addr == 1 && reg_wdata[3] != own));
        ptick = p_in && !clr && ((m_ev + 1) % div == 0);
        ctick = own ? src_ev : ptick;
        case (reg_addr)
            2'd0: exp_rd = m_cnt;
            2'd1: exp_rd = m_ctrl;
            2'd2: exp_rd = m_flag;
            default: exp_rd = 0;
        endcase
        if (rst_n) begin
            check(tag, reg_rdata, exp_rd, "rdata");
            check("R7", ovf_flag, m_flag, "flag");
            check(own ? "R5" : "R6", wdt_tick_out, own ? ptick : wdt_tick_in, "wdt_out");
        end
        @(posedge clk);
        if (!rst_n) model_reset();
        else begin
            if (ctick && m_cnt == 255 && !(reg_we && reg_addr == 0)) m_flag = 1;
            else if (reg_we && reg_addr == 2) m_flag = 0;
            if (reg_we && reg_addr == 0) m_cnt = reg_wdata;
            else if (ctick) m_cnt = (m_cnt + 1) % 256;
            m_ev = clr ? 0 : (m_ev + p_in) % 256;
            if (reg_we && reg_addr == 1) m_ctrl = reg_wdata;
            void'(pin_hist.pop_front());
            pin_hist.push_back(t_ext_pin);
        end
        #1;
    endtask

    task automatic wr(int a, int d);
        reg_we = 1; reg_addr = a[1:0]; reg_wdata = d[7:0];
        cyc();
        reg_we = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        cyc(); cyc();
        rst_n = 1;
        // R1: reset values on all addresses
        tag = "R1";
        for (int a = 0; a < 4; a++) begin reg_addr = a[1:0]; cyc(); end
        // R5: prescaler on watchdog, rate 2, internal source
        tag = "R5"; wr(1, 8'h0A); reg_addr = 0;
        for (int i = 0; i < 40; i++) begin icyc_en = i[0]; wdt_tick_in = (i % 3 == 0); cyc(); end
        // R4, R2: prescaler on counter, rate 1 (divide 4)
        tag = "R4"; wr(1, 8'h01); reg_addr = 0;
        for (int i = 0; i < 40; i++) begin icyc_en = 1; wdt_tick_in = i[1]; cyc(); end
        tag = "R2"; for (int i = 0; i < 20; i++) begin icyc_en = (i % 3 != 0); cyc(); end
        icyc_en = 0; wdt_tick_in = 0;
        // R3: pin rising edges, then falling edges, undivided
        tag = "R3"; wr(1, 8'h28); reg_addr = 0;
        for (int i = 0; i < 48; i++) begin t_ext_pin = (i % 6) < 3; cyc(); end
        wr(1, 8'h38); reg_addr = 0;
        for (int i = 0; i < 48; i++) begin t_ext_pin = (i % 8) < 3; cyc(); end
        t_ext_pin = 0;
        // R7: wrap from 0xFF sets flag
        tag = "R7"; wr(1, 8'h08); wr(0, 8'hFD); reg_addr = 2;
        icyc_en = 1; idle(6); icyc_en = 0;
        // R8: clear, then collision of overflow and clear
        tag = "R8"; wr(2, 0); cyc();
        wr(0, 8'hFE); icyc_en = 1; cyc(); icyc_en = 0;   // reaches FF, wraps next
        wr(0, 8'hFF); icyc_en = 1; wr(2, 0); icyc_en = 0;
        reg_addr = 2; cyc();
        check("R8", reg_rdata, 1, "flag after overflow+clear");
        wr(2, 0); cyc();
        check("R8", reg_rdata, 0, "flag after plain clear");
        // R9: load during prescaled advance
        tag = "R9"; wr(1, 8'h00); reg_addr = 0; icyc_en = 1; cyc();
        wr(0, 8'h40); reg_addr = 0; idle(5); icyc_en = 0;
        // R10: switch ownership mid-period, and same-owner rate change
        tag = "R10"; icyc_en = 1; wr(1, 8'h02); reg_addr = 0; idle(3);
        wr(1, 8'h03); reg_addr = 0; idle(20);
        wr(1, 8'h0B); reg_addr = 0; wdt_tick_in = 1; idle(5);
        wr(1, 8'h03); reg_addr = 0; idle(20); icyc_en = 0; wdt_tick_in = 0;
        // mixed random traffic
        tag = "R4";
        for (int i = 0; i < 3000; i++) begin
            icyc_en = $urandom_range(0, 1); wdt_tick_in = $urandom_range(0, 1);
            if ($urandom_range(0, 3) == 0) t_ext_pin = ~t_ext_pin;
            reg_addr = $urandom_range(0, 3);
            if ($urandom_range(0, 40) == 0) begin
                reg_we = 1; reg_wdata = $urandom_range(0, 255);
            end
            cyc(); reg_we = 0;
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule